// File: doc/BRIEF.md
# Commit-protected GPIO pad configuration

This block is the pad configuration register set for one GPIO port of `NPIN` pins (eight by default). Software writes it over a plain synchronous register bus: an address, a write strobe, write data, and combinational read data. It holds the pin-function, pull and input-enable settings and the drive-strength, open-drain and slew settings. From them it drives the per-pin pad control outputs, including a registered vector of enables for the individual current drivers of each pad.

Some pins carry the debug interface and the non-maskable interrupt. Their function, pull and input-enable bits are guarded. A write to them lands only after the port has been unlocked with a 32-bit key and the pin's commit bit has been set. Drive strength works in one of two ways, chosen per pin by a 2-bit mode field. In the ordinary way, the drive selects are one-hot. In the extended way, the selects stack on top of an always-on base driver. Some designated fast pins ignore part of the drive controls, or all of them.

Top module: `gpio_pad_cfg`

## Requirements
- R1: After reset the port is locked and every drive-select register holds 2 mA on all pins. The commit register holds 0 on protected pins and 1 elsewhere. All other registers are 0. The driver enables are 4'b0001 per pin, or 4'b0011 on fixed pins.
- R2: Lock register (address 10). A write of 32'h4C4F434B unlocks the port, and any other write locks it. It reads 1 when locked and 0 when unlocked.
- R3: On a protected pin (`PROT_MASK`), a write to the function select (0), pull-up (1), pull-down (2) or input enable (3) changes the stored bit only while the port is unlocked and that pin's commit bit is set.
- R4: On unprotected pins, writes to addresses 0 to 3 always land, whatever the lock state. Registers 0 to 3 drive `afsel_o`, `pu_o`, `pd_o` and `den_o` directly.
- R5: The commit register (address 11) takes a write only while the port is unlocked. Otherwise it is left as it was.
- R6: Drive-select registers are 2 mA (4), 4 mA (5), 8 mA (6) and 12 mA (7). On a pin whose effective mode is 0, a 1 written to one of them sets that select and clears the pin's other three, and a 0 leaves the pin unchanged. On a pin in extended mode, the written bit is stored as it is.
- R7: Each pin has four enables in `drv_en_o[4p+3:4p]`: bit 0 is the base 2 mA driver, bit 1 adds 2 mA, bit 2 adds 4 mA and bit 3 adds 4 mA. In mode 0 the enables are 1111 for 12 mA, 0111 for 8 mA, 0011 for 4 mA and 0001 otherwise, with priority in that order.
- R8: With extended drive supported and a non-zero mode, bit 0 is always set, bit 1 follows the 4 mA select and bit 2 follows the 8 mA select.
- R9: In extended drive, bit 3 follows the 12 mA select only in mode 3. Selecting 8 mA and 12 mA gives 10 mA, and selecting all of them gives 12 mA.
- R10: On fixed pins (`FIXED4_MASK`) the enables are held at 0011 (4 mA), and `od_o` and `slew_o` are held at 0, whatever the registers hold.
- R11: On pins in `NO12_MASK` the 12 mA select counts as clear in every mode. Bit 3 therefore stays 0.
- R12: `drv_en_o` is registered. It shows the state after a write one clock after the edge that takes the write. Register readback and the other outputs change at that edge.
- R13: Address map: open-drain 8, slew 9, mode 12 (pin p in bits 2p+1:2p). Unused bits and addresses 13 to 15 read 0. Every register reads back its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| afsel_o | output | NPIN | Alternate-function select per pin |
| pu_o | output | NPIN | Pull-up enable |
| pd_o | output | NPIN | Pull-down enable |
| den_o | output | NPIN | Digital input enable |
| od_o | output | NPIN | Open-drain enable |
| slew_o | output | NPIN | Slew-rate control enable |
| drv_en_o | output | 4*NPIN | Current-driver enables, four per pin |

## Verification
A write is driven at a falling edge and taken at the next rising edge. Readback and the level outputs are checked at the falling edge right after it. At that same falling edge, `drv_en_o` must still show the expected value from before the write. It must show the new value one falling edge later. The bench therefore checks the registered driver path against both cycles, so an early or a late update is caught. Reads are combinational and are checked shortly after the address is set, with the write strobe low.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DRV_W  = 4;
  localparam int unsigned N_PROT = 4;
  localparam int unsigned N_SEL  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_AFSEL  = 4'd0,
    A_PUR    = 4'd1,
    A_PDR    = 4'd2,
    A_DEN    = 4'd3,
    A_DR2    = 4'd4,
    A_DR4    = 4'd5,
    A_DR8    = 4'd6,
    A_DR12   = 4'd7,
    A_ODR    = 4'd8,
    A_SLR    = 4'd9,
    A_LOCK   = 4'd10,
    A_COMMIT = 4'd11,
    A_MODE   = 4'd12
  } reg_addr_e;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F434B;
endpackage

// File: rtl/gpio_prot_reg.sv
module gpio_prot_reg #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NPIN-1:0] data_i,
  input  logic [NPIN-1:0] allow_i,
  output logic [NPIN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (data_i & allow_i) | (q_o & ~allow_i);
  end
endmodule

// File: rtl/gpio_lock_commit.sv
module gpio_lock_commit
  import gpio_pad_pkg::*;
#(
  parameter int unsigned      NPIN      = 8,
  parameter logic [NPIN-1:0] PROT_MASK = 8'h1F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lock_i,
  input  logic              wr_commit_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              unlocked_o,
  output logic [NPIN-1:0]   commit_o,
  output logic [NPIN-1:0]   wr_ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o <= 1'b0;
      commit_o   <= ~PROT_MASK;
    end else begin
      if (wr_lock_i) unlocked_o <= (wr_data_i == UNLOCK_KEY);
      if (wr_commit_i && unlocked_o) commit_o <= wr_data_i[NPIN-1:0];
    end
  end

  // unprotected pins always writable; protected need unlock + commit
  assign wr_ok_o = ~PROT_MASK | (commit_o & {NPIN{unlocked_o}});
endmodule

// File: rtl/gpio_drive_sel.sv
module gpio_drive_sel
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SEL-1:0]           we_i,
  input  logic [NPIN-1:0]            data_i,
  input  logic [NPIN-1:0]            ext_i,
  output logic [N_SEL-1:0][NPIN-1:0] sel_o
);
  logic [N_SEL-1:0][NPIN-1:0] sel_d;

  always_comb begin
    sel_d = sel_o;
    for (int k = 0; k < N_SEL; k++) begin
      if (we_i[k]) begin
        for (int p = 0; p < NPIN; p++) begin
          if (ext_i[p]) begin
            sel_d[k][p] = data_i[p];
          end else if (data_i[p]) begin
            // default mode: one-hot per pin
            for (int j = 0; j < N_SEL; j++) sel_d[j][p] = (j == k);
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= '0;
      sel_o[0] <= '1;
    end else begin
      sel_o <= sel_d;
    end
  end
endmodule

// File: rtl/gpio_drive_decode.sv
module gpio_drive_decode #(
  parameter bit FIXED4 = 1'b0,
  parameter bit NO12   = 1'b0
) (
  input  logic [2:0] up_sel_i,  // {12mA, 8mA, 4mA}
  input  logic [1:0] mode_i,
  output logic [3:0] en_o
);
  logic d12;
  assign d12 = up_sel_i[2] & ~NO12;

  always_comb begin
    if (FIXED4)              en_o = 4'b0011;
    else if (mode_i == 2'd0) begin
      if (d12)               en_o = 4'b1111;
      else if (up_sel_i[1])  en_o = 4'b0111;
      else if (up_sel_i[0])  en_o = 4'b0011;
      else                   en_o = 4'b0001;
    end else begin
      en_o = {d12 & (mode_i == 2'd3), up_sel_i[1], up_sel_i[0], 1'b1};
    end
  end
endmodule

// File: rtl/gpio_pad_cfg.sv
module gpio_pad_cfg
  import gpio_pad_pkg::*;
#(
  parameter int unsigned      NPIN        = 8,
  parameter bit               EXT_DRV     = 1'b1,
  parameter logic [NPIN-1:0] PROT_MASK   = 8'h1F,
  parameter logic [NPIN-1:0] FIXED4_MASK = 8'hC0,
  parameter logic [NPIN-1:0] NO12_MASK   = 8'h30
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [NPIN-1:0]       afsel_o,
  output logic [NPIN-1:0]       pu_o,
  output logic [NPIN-1:0]       pd_o,
  output logic [NPIN-1:0]       den_o,
  output logic [NPIN-1:0]       od_o,
  output logic [NPIN-1:0]       slew_o,
  output logic [DRV_W*NPIN-1:0] drv_en_o
);
  localparam int unsigned MODE_W = 2 * NPIN;

  logic                       unlocked;
  logic [NPIN-1:0]            commit_q;
  logic [NPIN-1:0]            wr_ok;
  logic [N_PROT-1:0]          prot_we;
  logic [N_PROT-1:0][NPIN-1:0] prot_q;
  logic [N_SEL-1:0]           sel_we;
  logic [N_SEL-1:0][NPIN-1:0] sel_q;
  logic [NPIN-1:0]            od_q, slew_q, ext;
  logic [MODE_W-1:0]          mode_eff;
  logic [DRV_W*NPIN-1:0]      drv_d;

  gpio_lock_commit #(.NPIN(NPIN), .PROT_MASK(PROT_MASK)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_lock_i   (wr_en_i && addr_i == A_LOCK),
    .wr_commit_i (wr_en_i && addr_i == A_COMMIT),
    .wr_data_i   (wr_data_i),
    .unlocked_o  (unlocked),
    .commit_o    (commit_q),
    .wr_ok_o     (wr_ok)
  );

  for (genvar k = 0; k < N_PROT; k++) begin : g_prot
    assign prot_we[k] = wr_en_i && (addr_i == ADDR_W'(A_AFSEL + k));
    gpio_prot_reg #(.NPIN(NPIN)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (prot_we[k]),
      .data_i  (wr_data_i[NPIN-1:0]),
      .allow_i (wr_ok),
      .q_o     (prot_q[k])
    );
  end

  for (genvar k = 0; k < N_SEL; k++) begin : g_sel_we
    assign sel_we[k] = wr_en_i && (addr_i == ADDR_W'(A_DR2 + k));
  end

  gpio_drive_sel #(.NPIN(NPIN)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sel_we),
    .data_i (wr_data_i[NPIN-1:0]),
    .ext_i  (ext),
    .sel_o  (sel_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      od_q   <= '0;
      slew_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_ODR) od_q   <= wr_data_i[NPIN-1:0];
      if (addr_i == A_SLR) slew_q <= wr_data_i[NPIN-1:0];
    end
  end

  if (EXT_DRV) begin : g_mode
    logic [MODE_W-1:0] mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mode_q <= '0;
      else if (wr_en_i && addr_i == A_MODE) mode_q <= wr_data_i[MODE_W-1:0];
    end
    assign mode_eff = mode_q;
  end else begin : g_no_mode
    assign mode_eff = '0;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign ext[p] = |mode_eff[2*p +: 2];

    gpio_drive_decode #(.FIXED4(FIXED4_MASK[p]), .NO12(NO12_MASK[p])) u_dec (
      .up_sel_i ({sel_q[3][p], sel_q[2][p], sel_q[1][p]}),
      .mode_i   (mode_eff[2*p +: 2]),
      .en_o     (drv_d[DRV_W*p +: DRV_W])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drv_en_o[DRV_W*p +: DRV_W] <= FIXED4_MASK[p] ? 4'b0011 : 4'b0001;
      else         drv_en_o[DRV_W*p +: DRV_W] <= drv_d[DRV_W*p +: DRV_W];
    end
  end

  assign afsel_o = prot_q[0];
  assign pu_o    = prot_q[1];
  assign pd_o    = prot_q[2];
  assign den_o   = prot_q[3];
  assign od_o    = od_q & ~FIXED4_MASK;
  assign slew_o  = slew_q & ~FIXED4_MASK;

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_AFSEL, A_PUR, A_PDR, A_DEN: rd_data_o = DATA_W'(prot_q[addr_i[1:0]]);
      A_DR2, A_DR4, A_DR8, A_DR12:  rd_data_o = DATA_W'(sel_q[addr_i[1:0]]);
      A_ODR:    rd_data_o = DATA_W'(od_q);
      A_SLR:    rd_data_o = DATA_W'(slew_q);
      A_LOCK:   rd_data_o = DATA_W'(!unlocked);
      A_COMMIT: rd_data_o = DATA_W'(commit_q);
      A_MODE:   rd_data_o = DATA_W'(mode_eff);
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_cfg_chk.sv
module gpio_pad_cfg_chk
  import gpio_pad_pkg::*;
#(
  parameter int unsigned      NPIN        = 8,
  parameter logic [NPIN-1:0] PROT_MASK   = 8'h1F,
  parameter logic [NPIN-1:0] FIXED4_MASK = 8'hC0,
  parameter logic [NPIN-1:0] NO12_MASK   = 8'h30
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     wr_data_i,
  input logic                  unlocked,
  input logic [NPIN-1:0]       commit_q,
  input logic [2*NPIN-1:0]     mode_eff,
  input logic [NPIN-1:0]       afsel_o,
  input logic [NPIN-1:0]       od_o,
  input logic [NPIN-1:0]       slew_o,
  input logic [DRV_W*NPIN-1:0] drv_en_o
);
  a_r2_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_LOCK && wr_data_i != UNLOCK_KEY) |=> !unlocked);

  a_r3_prot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_AFSEL && !unlocked)
      |=> ((afsel_o & PROT_MASK) == ($past(afsel_o) & PROT_MASK)));

  a_r5_commit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_COMMIT && !unlocked) |=> $stable(commit_q));

  a_r10_no_od_slew: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((od_o & FIXED4_MASK) == '0) && ((slew_o & FIXED4_MASK) == '0));

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    a_r8_base_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_eff[2*p +: 2] != 2'd0) |=> drv_en_o[DRV_W*p]);

    a_r9_no_fourth: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_eff[2*p +: 2] == 2'd1 || mode_eff[2*p +: 2] == 2'd2)
        |=> !drv_en_o[DRV_W*p + 3]);

    if (NO12_MASK[p]) begin : g_no12
      a_r11_no_fourth: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drv_en_o[DRV_W*p + 3]);
    end

    if (FIXED4_MASK[p]) begin : g_fix
      a_r10_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drv_en_o[DRV_W*p +: DRV_W] == 4'b0011);
    end
  end
endmodule

bind gpio_pad_cfg gpio_pad_cfg_chk #(
  .NPIN(NPIN), .PROT_MASK(PROT_MASK), .FIXED4_MASK(FIXED4_MASK), .NO12_MASK(NO12_MASK)
) u_chk (.*);

// File: tb/gpio_pad_cfg_tb_top.sv
`timescale 1ns/1ps
module gpio_pad_cfg_tb_top;
  localparam int          NPIN  = 8;
  localparam logic [7:0]  PROT  = 8'h1F;
  localparam logic [7:0]  FIX   = 8'hC0;
  localparam logic [7:0]  NO12  = 8'h30;
  localparam logic [31:0] KEY   = 32'h4C4F434B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  afsel, pu, pd, den, od, slew;
  logic [31:0] drv_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pad_cfg #(.NPIN(NPIN), .EXT_DRV(1'b1), .PROT_MASK(PROT),
                 .FIXED4_MASK(FIX), .NO12_MASK(NO12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .afsel_o(afsel), .pu_o(pu),
    .pd_o(pd), .den_o(den), .od_o(od), .slew_o(slew), .drv_en_o(drv_en)
  );

  // reference model
  logic [7:0]  m_reg [4];   // afsel, pu, pd, den
  logic [7:0]  m_sel [4];   // 2,4,8,12 mA
  logic [7:0]  m_od, m_slew, m_commit;
  logic [15:0] m_mode;
  logic        m_unlk;

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin m_reg[k] = '0; m_sel[k] = '0; end
    m_sel[0] = 8'hFF; m_od = '0; m_slew = '0; m_commit = ~PROT;
    m_mode = '0; m_unlk = 1'b0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    logic [7:0] ok;
    ok = ~PROT | (m_commit & {8{m_unlk}});
    if (a <= 4'd3) m_reg[a] = (d[7:0] & ok) | (m_reg[a] & ~ok);
    else if (a <= 4'd7) begin
      for (int p = 0; p < NPIN; p++) begin
        if (m_mode[2*p +: 2] != 2'd0) m_sel[a-4][p] = d[p];
        else if (d[p]) for (int j = 0; j < 4; j++) m_sel[j][p] = (j == int'(a - 4));
      end
    end
    else if (a == 4'd8)  m_od = d[7:0];
    else if (a == 4'd9)  m_slew = d[7:0];
    else if (a == 4'd10) m_unlk = (d == KEY);
    else if (a == 4'd11) begin if (m_unlk) m_commit = d[7:0]; end
    else if (a == 4'd12) m_mode = d[15:0];
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    if (a <= 4'd3)  return {24'd0, m_reg[a]};
    if (a <= 4'd7)  return {24'd0, m_sel[a-4]};
    if (a == 4'd8)  return {24'd0, m_od};
    if (a == 4'd9)  return {24'd0, m_slew};
    if (a == 4'd10) return {31'd0, ~m_unlk};
    if (a == 4'd11) return {24'd0, m_commit};
    if (a == 4'd12) return {16'd0, m_mode};
    return '0;
  endfunction

  function automatic logic [3:0] exp_pin(input int p);
    logic [1:0] m;
    logic d12;
    if (FIX[p]) return 4'b0011;
    m = m_mode[2*p +: 2];
    d12 = m_sel[3][p] && !NO12[p];
    if (m == 2'd0) begin
      if (d12)          return 4'b1111;
      if (m_sel[2][p])  return 4'b0111;
      if (m_sel[1][p])  return 4'b0011;
      return 4'b0001;
    end
    return {d12 && (m == 2'd3), m_sel[2][p], m_sel[1][p], 1'b1};
  endfunction

  function automatic logic [31:0] exp_drv();
    logic [31:0] v;
    for (int p = 0; p < NPIN; p++) v[4*p +: 4] = exp_pin(p);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_levels();
    chk("R3/R4 afsel_o", {24'd0, afsel}, {24'd0, m_reg[0]});
    chk("R3/R4 pu_o",    {24'd0, pu},    {24'd0, m_reg[1]});
    chk("R3/R4 pd_o",    {24'd0, pd},    {24'd0, m_reg[2]});
    chk("R3/R4 den_o",   {24'd0, den},   {24'd0, m_reg[3]});
    chk("R10 od_o",      {24'd0, od},    {24'd0, m_od & ~FIX});
    chk("R10 slew_o",    {24'd0, slew},  {24'd0, m_slew & ~FIX});
  endtask

  task automatic chk_drv(input logic [31:0] exp);
    for (int p = 0; p < NPIN; p++) begin
      if (FIX[p])       chk("R10 drv_en", {28'd0, drv_en[4*p +: 4]}, {28'd0, exp[4*p +: 4]});
      else if (NO12[p]) chk("R11 drv_en", {28'd0, drv_en[4*p +: 4]}, {28'd0, exp[4*p +: 4]});
      else              chk("R7/R8/R9 drv_en", {28'd0, drv_en[4*p +: 4]}, {28'd0, exp[4*p +: 4]});
    end
  endtask

  function automatic string rd_tag(input logic [3:0] a);
    if (a <= 4'd3)  return "R3/R4 readback";
    if (a <= 4'd7)  return "R6 readback";
    if (a == 4'd10) return "R2 lock read";
    if (a == 4'd11) return "R5 commit read";
    return "R13 readback";
  endfunction

  task automatic read_chk(input logic [3:0] a);
    addr = a;
    #0.5;
    chk(rd_tag(a), rdata, exp_rd(a));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] old_drv;
    @(negedge clk);
    old_drv = exp_drv();
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    chk("R12 drv_en before update", drv_en, old_drv);
    chk_levels();
    read_chk(a);
    @(negedge clk);
    chk_drv(exp_drv());
  endtask

  initial begin : watchdog
    int cyc;
    for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [3:0] a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      addr = 4'(i); #0.5;
      chk("R1 reset read", rdata, exp_rd(4'(i)));
    end
    chk("R1 reset drv_en", drv_en, exp_drv());

    // R3/R4: locked writes hit only unprotected pins
    wr(4'd0, 32'hFF);
    wr(4'd1, 32'hFF);
    // R5: commit ignored while locked
    wr(4'd11, 32'hFF);
    // R2: wrong key keeps it locked, key unlocks
    wr(4'd10, 32'h4C4F434A);
    wr(4'd10, KEY);
    // unlocked but commit bits clear: still held
    wr(4'd2, 32'hFF);
    wr(4'd11, 32'h03);
    wr(4'd3, 32'hFF);
    wr(4'd0, 32'h00);
    wr(4'd10, 32'h0);
    wr(4'd3, 32'h00);
    // R13: unmapped reads
    read_chk(4'd13);
    read_chk(4'd15);

    // R6..R11: every mode and select combination
    for (int m = 0; m < 4; m++) begin
      wr(4'd12, {16'd0, {8{2'(m)}}});
      for (int c = 0; c < 16; c++) begin
        wr(4'd5, c[1] ? 32'hFF : 32'h00);
        wr(4'd6, c[2] ? 32'hFF : 32'h00);
        wr(4'd7, c[3] ? 32'hFF : 32'h00);
        wr(4'd4, c[0] ? 32'hFF : 32'h00);
      end
    end

    // mixed per-pin modes, random traffic
    for (int i = 0; i < 600; i++) begin
      a = 4'($urandom % 13);
      d = $urandom;
      if (a == 4'd10 && $urandom % 2 == 0) d = KEY;
      wr(a, d);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule